// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches the clock and data lines of a two-wire serial bus using a much faster system clock. Each raw line first passes through a synchronizer. A persistence filter then suppresses short spikes, so a level reaches the filtered output only after it has held for a set number of system cycles. From the two filtered lines the block decodes framing conditions. A falling data line while the clock is high opens a transaction. A rising data line while the clock is high closes it. Every rising edge of the filtered clock inside a transaction gives a one-cycle sample strobe.

A bus-free timer counts consecutive system cycles in which no transaction is open and both filtered lines are high. A fresh opening condition is accepted only after this count reaches the configured minimum. An opening condition seen while a transaction is already open is reported as a repeated start. The block neither drives the data line nor assembles bytes. It is meant to sit in front of a target or monitor engine that consumes the strobes.

Top module: `twl_bus_monitor`

## Requirements
- R1: While reset is held, both filtered outputs are 1, `busy_o` and `free_ok_o` are 0, and all four strobes are 0.
- R2: A pulse on either raw line that lasts fewer than `GLITCH_CYCLES` system cycles leaves both filtered outputs unchanged. It produces no strobe and does not disturb `free_ok_o`.
- R3: When a raw line changes and then holds, the filtered output still shows the old level `SYNC_STAGES+GLITCH_CYCLES-1` cycles after the change. It shows the new level within `SYNC_STAGES+GLITCH_CYCLES+1` cycles.
- R4: `free_ok_o` goes to 1 after `FREE_CYCLES` consecutive cycles in which both filtered lines are high and `busy_o` is 0. It returns to 0 the cycle after either filtered line goes low, and it is never 1 while `busy_o` is 1.
- R5: A filtered data fall while the filtered clock is high, with `busy_o` 0 and `free_ok_o` 1, gives exactly one single-cycle `start_o` pulse. `busy_o` is set on the following cycle.
- R6: The same data fall while `busy_o` is 0 and `free_ok_o` is 0 is ignored. No `start_o` pulse occurs, `busy_o` stays 0, and later clock rises give no `sample_o`.
- R7: A filtered data fall while the filtered clock is high and `busy_o` is 1 gives one `rstart_o` pulse instead of `start_o`, and `busy_o` stays 1.
- R8: A filtered data rise while the filtered clock is high and `busy_o` is 1 gives one `stop_o` pulse and clears `busy_o` on the next cycle. The same rise while `busy_o` is 0 gives no `stop_o`.
- R9: `sample_o` pulses for exactly one cycle on each filtered clock rise while `busy_o` is 1, and never while `busy_o` is 0.
- R10: A data change while the filtered clock is low produces no `start_o`, `rstart_o` or `stop_o`. At most one of the four strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| scl_o | output | 1 | Filtered bus clock level |
| sda_o | output | 1 | Filtered bus data level |
| start_o | output | 1 | Strobe: accepted opening condition |
| rstart_o | output | 1 | Strobe: repeated opening condition |
| stop_o | output | 1 | Strobe: closing condition |
| sample_o | output | 1 | Strobe: clock rise inside a transaction |
| busy_o | output | 1 | A transaction is open |
| free_ok_o | output | 1 | Bus has been free long enough for a new transaction |

## Verification
The bench targets several corner cases. One is a data fall that arrives after a closing condition but before the free timer has expired; a design that skipped the timer would open a transaction there and then emit sample strobes on the clock rise that follows. Another is a repeated opening condition, which a design would report as a plain start if it failed to separate the two cases. A third is a data change while the clock is low, which a careless decoder would read as framing. Spikes one cycle shorter than the filter window are sent on each line, in both the idle and busy states, and a window that is off by one would pass them through. The filter latency is checked on both sides of its bound.

// File: rtl/twl_cond_pkg.sv
package twl_cond_pkg;
   localparam int NUM_LINES = 2;
   typedef enum logic [0:0] {
      LINE_SCL = 1'b0,
      LINE_SDA = 1'b1
   } twl_line_e;
endpackage

// File: rtl/twl_glitch_filter.sv
module twl_glitch_filter #(
   parameter int  SYNC_STAGES   = 2,
   parameter int  HOLD_CYCLES   = 10,
   parameter bit  RESET_LEVEL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);

   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (HOLD_CYCLES < 1) $error("HOLD_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   // synchronizer chain, first stage takes the raw pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= RESET_LEVEL;
      else        sync_q[0] <= raw_i;
   end

   for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[g] <= RESET_LEVEL;
         else        sync_q[g] <= sync_q[g-1];
      end
   end

   logic          smp;
   logic [CW-1:0] run_q;
   logic          lvl_q;

   assign smp = sync_q[SYNC_STAGES-1];

   // persistence filter: a new level must be seen HOLD_CYCLES times in a row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= RESET_LEVEL;
         run_q <= '0;
      end else if (smp == lvl_q) begin
         run_q <= '0;
      end else if (run_q == CW'(HOLD_CYCLES - 1)) begin
         lvl_q <= smp;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign level_o = lvl_q;
endmodule

// File: rtl/twl_free_timer.sv
module twl_free_timer #(
   parameter int FREE_CYCLES = 260
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle_i,
   output logic ready_o
);
   localparam int CW = $clog2(FREE_CYCLES + 1);

   initial begin
      if (FREE_CYCLES < 1) $error("FREE_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!idle_i)                    cnt_q <= '0;
      else if (cnt_q != CW'(FREE_CYCLES))  cnt_q <= cnt_q + 1'b1;
   end

   assign ready_o = (cnt_q == CW'(FREE_CYCLES));
endmodule

// File: rtl/twl_cond_detect.sv
module twl_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   input  logic free_ok,
   output logic start_o,
   output logic rstart_o,
   output logic stop_o,
   output logic sample_o,
   output logic busy_o
);
   logic scl_d, sda_d, busy_q;
   logic fall_hi, rise_hi, clk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   // framing needs the clock high on both sides of the data edge
   assign fall_hi  = scl_f & scl_d & sda_d & ~sda_f;
   assign rise_hi  = scl_f & scl_d & ~sda_d & sda_f;
   assign clk_rise = scl_f & ~scl_d;

   assign start_o  = fall_hi & ~busy_q & free_ok;
   assign rstart_o = fall_hi & busy_q;
   assign stop_o   = rise_hi & busy_q;
   assign sample_o = clk_rise & busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_q <= 1'b0;
      else if (start_o) busy_q <= 1'b1;
      else if (stop_o)  busy_q <= 1'b0;
   end

   assign busy_o = busy_q;
endmodule

// File: rtl/twl_bus_monitor.sv
module twl_bus_monitor
   import twl_cond_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int GLITCH_CYCLES = 10,
   parameter int FREE_CYCLES   = 260
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic start_o,
   output logic rstart_o,
   output logic stop_o,
   output logic sample_o,
   output logic busy_o,
   output logic free_ok_o
);
   logic [NUM_LINES-1:0] raw_lines, flt_lines;
   logic                 idle, ready;

   assign raw_lines[LINE_SCL] = scl_i;
   assign raw_lines[LINE_SDA] = sda_i;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      twl_glitch_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .HOLD_CYCLES (GLITCH_CYCLES),
         .RESET_LEVEL (1'b1)
      ) u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_i   (raw_lines[l]),
         .level_o (flt_lines[l])
      );
   end

   assign scl_o = flt_lines[LINE_SCL];
   assign sda_o = flt_lines[LINE_SDA];

   assign idle = scl_o & sda_o & ~busy_o;

   twl_free_timer #(.FREE_CYCLES(FREE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .idle_i  (idle),
      .ready_o (ready)
   );

   assign free_ok_o = ready;

   twl_cond_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_o),
      .sda_f    (sda_o),
      .free_ok  (ready),
      .start_o  (start_o),
      .rstart_o (rstart_o),
      .stop_o   (stop_o),
      .sample_o (sample_o),
      .busy_o   (busy_o)
   );
endmodule

// File: rtl/twl_bus_monitor_chk.sv
module twl_bus_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_o,
   input logic start_o,
   input logic rstart_o,
   input logic stop_o,
   input logic sample_o,
   input logic busy_o,
   input logic free_ok_o
);
   p_start_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> busy_o && !start_o);

   p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> free_ok_o && !busy_o);

   p_rstart_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rstart_o |=> busy_o);

   p_stop_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !busy_o);

   p_sample_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> busy_o);

   p_free_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      free_ok_o |-> !busy_o);

   p_free_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sda_o |=> !free_ok_o);

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_o, rstart_o, stop_o, sample_o}));
endmodule

bind twl_bus_monitor twl_bus_monitor_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_o     (sda_o),
   .start_o   (start_o),
   .rstart_o  (rstart_o),
   .stop_o    (stop_o),
   .sample_o  (sample_o),
   .busy_o    (busy_o),
   .free_ok_o (free_ok_o)
);

// File: tb/tb_twl_bus_monitor.sv
`timescale 1ns/1ps
module tb_twl_bus_monitor;
   localparam int SYNC = 2;
   localparam int G    = 10;
   localparam int FREE = 260;
   localparam int SEG  = 40;
   localparam int NV   = 18;

   // row bits: [6] scl [5] sda [4] start [3] rstart [2] stop [1] sample [0] busy at end
   localparam logic [6:0] VEC [NV] = '{
      7'b1010001, 7'b0000001, 7'b0100001, 7'b1100011, 7'b0100001, 7'b0000001,
      7'b1000011, 7'b0000001, 7'b0100001, 7'b1100011, 7'b1001001, 7'b0000001,
      7'b1000011, 7'b1100100, 7'b1000000, 7'b0000000, 7'b1000000, 7'b1100000
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_i = 1'b1, sda_i = 1'b1;
   logic scl_o, sda_o, start_o, rstart_o, stop_o, sample_o, busy_o, free_ok_o;

   int checks = 0, fails = 0;
   int n_st = 0, n_rs = 0, n_sp = 0, n_sm = 0, n_sda_chg = 0, n_scl_chg = 0;
   bit done = 1'b0;
   logic sda_prev = 1'b1, scl_prev = 1'b1;

   always #2.5 clk = ~clk;

   twl_bus_monitor #(.SYNC_STAGES(SYNC), .GLITCH_CYCLES(G), .FREE_CYCLES(FREE)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .rstart_o(rstart_o),
      .stop_o(stop_o), .sample_o(sample_o), .busy_o(busy_o), .free_ok_o(free_ok_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         n_st += int'(start_o);
         n_rs += int'(rstart_o);
         n_sp += int'(stop_o);
         n_sm += int'(sample_o);
         if (sda_o !== sda_prev) n_sda_chg++;
         if (scl_o !== scl_prev) n_scl_chg++;
      end
      sda_prev = sda_o;
      scl_prev = scl_o;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int b_st, b_rs, b_sp, b_sm, b_sc;
      hold(3);
      // R1 reset state
      chk("R1 scl_o", int'(scl_o), 1);
      chk("R1 sda_o", int'(sda_o), 1);
      chk("R1 busy_o", int'(busy_o), 0);
      chk("R1 free_ok_o", int'(free_ok_o), 0);
      chk("R1 strobes", int'({start_o, rstart_o, stop_o, sample_o}), 0);
      rst_n = 1'b1;
      hold(FREE - 20);
      chk("R4 free_ok early", int'(free_ok_o), 0);
      hold(60);
      chk("R4 free_ok set", int'(free_ok_o), 1);

      // vector walk: R5 R6 R7 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         b_st = n_st; b_rs = n_rs; b_sp = n_sp; b_sm = n_sm;
         scl_i = VEC[i][6];
         sda_i = VEC[i][5];
         hold(SEG);
         $display("row %0d (R5 R6 R7 R8 R9 R10)", i);
         chk("R5/R6 start count", n_st - b_st, int'(VEC[i][4]));
         chk("R7 rstart count", n_rs - b_rs, int'(VEC[i][3]));
         chk("R8 stop count", n_sp - b_sp, int'(VEC[i][2]));
         chk("R9 sample count", n_sm - b_sm, int'(VEC[i][1]));
         chk("R10 busy level", int'(busy_o), int'(VEC[i][0]));
      end

      // R4: free again after a full idle window, cleared by data low
      hold(FREE + 20);
      chk("R4 free_ok after idle", int'(free_ok_o), 1);

      // R2: short spikes on each line while idle
      b_st = n_st; b_sc = n_sda_chg;
      sda_i = 1'b0; hold(G - 1); sda_i = 1'b1; hold(SEG);
      chk("R2 sda spike filtered", n_sda_chg - b_sc, 0);
      chk("R2 no start from spike", n_st - b_st, 0);
      chk("R2 free_ok kept", int'(free_ok_o), 1);
      b_sc = n_scl_chg;
      scl_i = 1'b0; hold(G - 1); scl_i = 1'b1; hold(SEG);
      chk("R2 scl spike filtered", n_scl_chg - b_sc, 0);
      chk("R2 busy stays low", int'(busy_o), 0);

      // R3 latency bound and R5 start
      b_st = n_st;
      sda_i = 1'b0;
      hold(SYNC + G - 1);
      chk("R3 old level held", int'(sda_o), 1);
      hold(2);
      chk("R3 new level seen", int'(sda_o), 0);
      hold(1);
      chk("R4 free_ok dropped", int'(free_ok_o), 0);
      hold(SEG);
      chk("R5 start accepted", n_st - b_st, 1);
      chk("R5 busy set", int'(busy_o), 1);

      // R2/R9: clock spike while busy gives no sample
      scl_i = 1'b0; hold(SEG);
      b_sm = n_sm;
      scl_i = 1'b1; hold(G - 1); scl_i = 1'b0; hold(SEG);
      chk("R2 R9 no sample from spike", n_sm - b_sm, 0);
      scl_i = 1'b1; hold(SEG);
      chk("R9 sample on real rise", n_sm - b_sm, 1);

      // R8 stop closes
      b_sp = n_sp;
      sda_i = 1'b1; hold(SEG);
      chk("R8 stop seen", n_sp - b_sp, 1);
      chk("R8 busy cleared", int'(busy_o), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule